// File: doc/BRIEF.md
# Synchronous Byte-Wide Configuration Receiver

This block receives configuration data one byte at a time on the device side. All of its timing comes from a configuration clock that an outside master supplies. The block waits until its initialization-done input goes high. It then takes a byte from the 8-bit data bus at fixed rising-edge positions and hands each byte to internal configuration memory through a one-cycle valid strobe. It raises an acknowledge output for one clock after every capture. The captured byte is also sent out again, most significant bit first, on a serial output that feeds the next device in a daisy chain. That shifting is done on falling clock edges.

The master keeps the data bus stable around each rising edge. It must keep clocking after the final byte so that the serial copy of that byte can leave the chip. While initialization-done is low the block stays idle with its edge counter cleared. Each new rise of that input starts the byte grid again.

Top module: `cfgsp_rx`

## Requirements
- R1: After a rising edge that samples `init_done` high while the block is idle, the next rising edge captures the first byte. `byte_vld` is 1 and `byte_q` holds the `din` value sampled at that second edge, and both are visible right after that edge.
- R2: Every later capture happens on the eighth rising edge after the previous capture, provided `init_done` stays high. `byte_vld` is 0 on all edges in between.
- R3: `ack` is 1 for exactly one clock after each capture and is 0 at all other times. `byte_q` keeps the captured value until the next capture.
- R4: On the falling edge after a capture, `sdout` presents bit 7 of the captured byte. Each following falling edge presents the next lower bit, so all 8 bits leave before the next load.
- R5: After the last capture the shifter keeps running on falling edges whether or not `init_done` is high. Once the 8 bits have left, `sdout` is 0.
- R6: While `init_done` is sampled low, no capture happens and the edge counter is cleared. When it is sampled high again, the first capture follows on the second rising edge, as in R1.
- R7: `byte_cnt` increases by one on each capture, wrapping modulo 2^CNT_W. It is cleared only by reset.
- R8: While `rst_n` is low, `ack`, `byte_vld`, `byte_q`, `byte_cnt` and `sdout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock from the external master |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | High once initialization is complete; enables capture |
| din | input | 8 | Parallel configuration data bus |
| ack | output | 1 | One-clock acknowledge after each capture |
| sdout | output | 1 | Serial daisy-chain output, MSB first, changes on falling edges |
| byte_vld | output | 1 | One-clock strobe to configuration memory |
| byte_q | output | 8 | Last captured byte |
| byte_cnt | output | CNT_W | Capture counter, wraps |

## Verification
The bench hunts for off-by-one errors in the edge grid. A design that captured on the first edge after init, or every seventh or ninth edge, would latch the wrong incrementing bus value and put its strobe in the wrong cycle. Dropping init in the middle of a byte period checks that the grid really restarts. A design that kept a stale phase would capture early after the rise. The serial stream is rebuilt bit by bit, including the drain after init falls. This catches LSB-first order, shifting on the rising edge, and a missing zero fill after the last bit. Running more than sixteen bytes drives the counter through its wrap.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  typedef enum logic {
    GRID_IDLE = 1'b0,
    GRID_RUN  = 1'b1
  } grid_state_t;

  // Advance the edge position inside one byte period.
  function automatic int unsigned phase_step(input int unsigned ph, input int unsigned period);
    return (ph + 1) % period;
  endfunction

  // A byte is taken when the running grid sits at position zero.
  function automatic logic is_capture_slot(input int unsigned ph);
    return (ph == 0);
  endfunction

endpackage

// File: rtl/cfgsp_phase.sv
module cfgsp_phase
  import cfgsp_pkg::*;
#(
  parameter int unsigned PERIOD = 8,
  localparam int unsigned PH_W = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  output logic cap_fire
);

  grid_state_t       st;
  logic [PH_W-1:0]   ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= GRID_IDLE;
      ph <= '0;
    end else if (!init) begin
      st <= GRID_IDLE;
      ph <= '0;
    end else if (st == GRID_IDLE) begin
      st <= GRID_RUN;
      ph <= '0;
    end else begin
      ph <= PH_W'(phase_step(32'(ph), PERIOD));
    end
  end

  assign cap_fire = (st == GRID_RUN) && init && is_capture_slot(32'(ph));

  // R6: an edge that sees init low leaves no capture on the following edge
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> !cap_fire);

  // R2: captures are never back to back
  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> !cap_fire);

endmodule

// File: rtl/cfgsp_latch.sv
module cfgsp_latch #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_fire,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] byte_q,
  output logic              byte_vld,
  output logic              ack,
  output logic [CNT_W-1:0]  byte_cnt
);

  logic vld_r;
  logic ack_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q   <= '0;
      vld_r    <= 1'b0;
      ack_r    <= 1'b0;
      byte_cnt <= '0;
    end else begin
      vld_r <= cap_fire;
      ack_r <= cap_fire;
      if (cap_fire) begin
        byte_q   <= din;
        byte_cnt <= byte_cnt + 1'b1;
      end
    end
  end

  assign byte_vld = vld_r;
  assign ack      = ack_r;

  // R3: acknowledge lasts a single clock
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R3: the presented byte is the bus value at the capture edge
  p_capture_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_q == $past(din));

  // R7: counter steps by one per capture
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> byte_cnt == CNT_W'($past(byte_cnt) + 1'b1));

  // R7: counter holds when nothing is captured
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |-> $stable(byte_cnt));

endmodule

// File: rtl/cfgsp_shift.sv
module cfgsp_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] byte_q,
  output logic              sdout
);

  logic [DATA_W-2:0] rest;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdout <= 1'b0;
      rest  <= '0;
    end else if (load) begin
      sdout <= byte_q[DATA_W-1];
      rest  <= byte_q[DATA_W-2:0];
    end else begin
      sdout <= rest[DATA_W-2];
      rest  <= {rest[DATA_W-3:0], 1'b0};
    end
  end

  // R4: the first serial bit after a load is the byte's top bit
  p_msb_first_r4: assert property (@(negedge clk) disable iff (!rst_n)
    load |=> sdout == $past(byte_q[DATA_W-1]));

  // R4: the second serial bit is the next lower bit
  p_second_bit_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (load && $past(rst_n)) |=> ##1 sdout == $past(byte_q[DATA_W-2], 2));

endmodule

// File: rtl/cfgsp_rx.sv
module cfgsp_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PERIOD = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic [DATA_W-1:0] din,
  output logic              ack,
  output logic              sdout,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_q,
  output logic [CNT_W-1:0]  byte_cnt
);

  logic cap_fire;

  cfgsp_phase #(.PERIOD(PERIOD)) u_phase (
    .clk      (cfg_clk),
    .rst_n    (rst_n),
    .init     (init_done),
    .cap_fire (cap_fire)
  );

  cfgsp_latch #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_latch (
    .clk      (cfg_clk),
    .rst_n    (rst_n),
    .cap_fire (cap_fire),
    .din      (din),
    .byte_q   (byte_q),
    .byte_vld (byte_vld),
    .ack      (ack),
    .byte_cnt (byte_cnt)
  );

  cfgsp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk    (cfg_clk),
    .rst_n  (rst_n),
    .load   (byte_vld),
    .byte_q (byte_q),
    .sdout  (sdout)
  );

  // R1: a strobe follows only an edge that saw init high
  p_init_gate_r1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    byte_vld |-> $past(init_done));

  // R3: acknowledge and memory strobe agree
  p_ack_match_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    ack == byte_vld);

endmodule

// File: tb/cfgsp_rx_test.sv
module cfgsp_rx_test;

  logic       cfg_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_done = 1'b0;
  logic [7:0] din = 8'h00;
  logic       ack, sdout, byte_vld;
  logic [7:0] byte_q;
  logic [3:0] byte_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int   m_run = 0, m_ph = 0, m_cnt = 0;
  bit   m_vld = 0;
  logic [7:0] m_q = 0;
  bit   m_sd = 0;
  bit   m_bits[$];

  cfgsp_rx uut (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .init_done(init_done), .din(din),
    .ack(ack), .sdout(sdout), .byte_vld(byte_vld), .byte_q(byte_q), .byte_cnt(byte_cnt)
  );

  always #4 cfg_clk = ~cfg_clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_rise();
    bit cap;
    if (!rst_n) begin
      m_run = 0; m_ph = 0; m_cnt = 0; m_vld = 0; m_q = 0;
      return;
    end
    cap = (m_run != 0) && init_done && (m_ph == 0);
    m_vld = cap;
    if (cap) begin
      m_q = din;
      m_cnt = (m_cnt + 1) % 16;
    end
    if (!init_done) begin m_run = 0; m_ph = 0; end
    else if (m_run == 0) begin m_run = 1; m_ph = 0; end
    else m_ph = (m_ph + 1) % 8;
  endtask

  task automatic model_fall();
    if (!rst_n) begin m_sd = 0; m_bits.delete(); return; end
    if (m_vld) begin
      m_bits.delete();
      for (int i = 7; i >= 0; i--) m_bits.push_back(m_q[i]);
    end
    m_sd = (m_bits.size() > 0) ? m_bits.pop_front() : 1'b0;
  endtask

  task automatic compare();
    check(byte_vld == m_vld, "R2 byte_vld", byte_vld, m_vld);
    check(ack == m_vld, "R3 ack", ack, m_vld);
    check(byte_q == m_q, "R3 byte_q", byte_q, m_q);
    check(sdout == m_sd, "R4 sdout", sdout, m_sd);
    check(byte_cnt == 4'(m_cnt), "R7 byte_cnt", byte_cnt, m_cnt);
  endtask

  // One clock: model the rising edge, drive next inputs, model the falling edge, compare.
  task automatic cycle(input bit rn, input bit ini, input logic [7:0] d);
    @(posedge cfg_clk);
    model_rise();
    #1;
    rst_n = rn; init_done = ini; din = d;
    #3;
    model_fall();
    #3;
    compare();
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] rebuilt;
    int gap;
    d = 8'h10;

    // reset
    cycle(0, 1, 8'h5a);
    cycle(0, 1, 8'h5a);
    check(ack == 0 && byte_vld == 0 && byte_q == 0 && byte_cnt == 0 && sdout == 0,
          "R8 reset outputs", {ack, byte_vld, sdout}, 0);
    cycle(1, 0, 8'h00);
    cycle(1, 0, 8'h00);

    // R1: first capture on second edge with init high
    cycle(1, 1, 8'h11);
    cycle(1, 1, 8'h22);
    check(byte_vld == 0, "R1 no capture on first edge", byte_vld, 0);
    cycle(1, 1, 8'h33);
    check(byte_vld == 1 && byte_q == 8'h22, "R1 first capture value", byte_q, 8'h22);
    rebuilt = {7'b0, sdout};

    // R2 and R4: next capture eight edges later, serial bits rebuild the byte
    gap = 0;
    d = 8'h40;
    for (int i = 0; i < 8; i++) begin
      cycle(1, 1, d);
      d++;
      gap++;
      if (i < 7) rebuilt = {rebuilt[6:0], sdout};
      if (byte_vld) break;
    end
    check(gap == 8, "R2 capture spacing", gap, 8);
    check(rebuilt == 8'h22, "R4 serial msb first", rebuilt, 8'h22);
    check(byte_q == 8'h46, "R2 second capture value", byte_q, 8'h46);

    // R6: init drop in the middle of a period restarts the grid
    cycle(1, 1, 8'h01);
    cycle(1, 1, 8'h02);
    cycle(1, 0, 8'h03);
    cycle(1, 0, 8'h04);
    check(byte_vld == 0, "R6 no capture while low", byte_vld, 0);
    cycle(1, 1, 8'h05);
    check(byte_vld == 0, "R6 no capture while low", byte_vld, 0);
    cycle(1, 1, 8'h66);
    check(byte_vld == 0, "R6 restart first edge", byte_vld, 0);
    cycle(1, 1, 8'h77);
    check(byte_vld == 1 && byte_q == 8'h66, "R6 restart capture", byte_q, 8'h66);

    // random traffic with occasional init drops, counter wrap
    for (int i = 0; i < 400; i++) begin
      cycle(1, ($urandom % 40) != 0, 8'($urandom));
    end

    // R5: last byte drains after init falls
    for (int i = 0; i < 9; i++) begin
      cycle(1, 1, 8'hc5);
      if (byte_vld) break;
    end
    check(byte_vld == 1, "R5 final capture seen", byte_vld, 1);
    rebuilt = {7'b0, sdout};
    for (int i = 0; i < 7; i++) begin
      cycle(1, 0, 8'h00);
      rebuilt = {rebuilt[6:0], sdout};
    end
    check(rebuilt == byte_q, "R5 drained byte", rebuilt, byte_q);
    cycle(1, 0, 8'h00);
    check(sdout == 0, "R5 zero after drain", sdout, 0);
    cycle(1, 0, 8'h00);
    check(sdout == 0, "R5 zero after drain", sdout, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule